// File: doc/BRIEF.md
# Branching Bus Self-Test Sequencer

This block runs a small self-test program over an AXI4-Lite master port and needs no processor. Its program sits in a parameter-loaded table. Each entry holds four words: an address, a data word, a control word and a compare mask. Starting at entry 0, the sequencer carries out one transaction per entry, judges the result, and picks the next entry from one of two indices in the control word. One index is taken on success and the other on failure. A chip can therefore bring up and probe its peripherals through a fixed script that contains loops, retries and error exits.

A write is judged by its write response alone. A read is judged by its read response and by comparing the returned data with the entry's data word. The comparison covers only the bits selected by the mask. Each entry can choose whether a failure adds to a saturating error counter. The program stops at an entry whose address is all ones. It also stops, with an error flag, at an entry whose control word has any of its unused high bits set. After stopping, the block holds `done` and reports a pass/fail `status`.

Top module: `lite_test_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` and `status` are 0, `err_count` is 0 and no valid output is high.
- R2: An entry whose address is all ones ends the program without any bus transaction: `done` rises and then holds, and `err_count` no longer changes. This check comes before the control-word check.
- R3: Control bit 16 set makes the entry a write. The entry's address is driven on the write-address channel and its data word on the write-data channel. The write succeeds exactly when the write response is OKAY (2'b00).
- R4: Control bit 16 clear makes the entry a read at the entry's address. The read succeeds when the read response is OKAY and the returned data equals the data word on every bit where the mask is 1. Bits where the mask is 0 are not compared, and the mask has no effect on writes.
- R5: After a success, the next entry is control bits 15:8; after a failure it is control bits 7:0. Either index is taken modulo the table depth.
- R6: A failure adds one to `err_count` when control bit 17 is 1. When bit 17 is 0 the result is still judged and branched on, but the counter is unchanged.
- R7: `err_count` (width ERR_W) stops at its all-ones value and never wraps.
- R8: When the program ends at an all-ones address, `status` is 1 exactly when `err_count` is 0.
- R9: An entry with any of control bits 31:18 set is not issued. The program ends with `done` at 1, `status` at 0, and `err_count` left unchanged.
- R10: Only one transaction is outstanding at a time, and a read address and a write address are never offered together. Each valid stays high, with its payload unchanged, until it is accepted.
- R11: Every write drives all byte strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_awaddr | output | ADDR_W | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| done | output | 1 | Program has ended |
| status | output | 1 | 1 when the program ended with no counted error |
| err_count | output | ERR_W | Saturating count of counted failures |

## Verification
The hardest condition to reach from the ports is a branch taken on a failed check. That needs a slave that answers with an error, or that returns data which differs from the expected word on compared bits but not on masked bits. The test slave returns an error response for every address with bit 8 set and keeps a real memory for all other addresses. The programs write known words and then read them back under partial masks. Saturation uses a build with a two-bit counter and a chain of failing writes. A separate program places a reserved control bit after one good write.

// File: rtl/lts_pkg.sv
package lts_pkg;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // control word layout; bit positions are decoded by the sequencer
  typedef struct packed {
    logic [13:0] rsv;       // must be zero
    logic        count_en;  // failure counts as an error
    logic        is_write;  // 1 write, 0 read
    logic [7:0]  go_pass;   // next entry on success
    logic [7:0]  go_fail;   // next entry on failure
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_PICK  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_FINAL = 2'd2
  } seq_state_t;

  function automatic logic ctrl_legal(ctrl_t c);
    return c.rsv == '0;
  endfunction

endpackage

// File: rtl/lts_rom.sv
module lts_rom
  import lts_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter logic [DEPTH*ADDR_W-1:0] P_ADDR = '1,
  parameter logic [DEPTH*DATA_W-1:0] P_DATA = '0,
  parameter logic [DEPTH*32-1:0]     P_CTRL = '0,
  parameter logic [DEPTH*DATA_W-1:0] P_MASK = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output ctrl_t             rd_ctrl,
  output logic [DATA_W-1:0] rd_mask
);

  logic [ADDR_W-1:0] a_arr [DEPTH];
  logic [DATA_W-1:0] d_arr [DEPTH];
  ctrl_t             c_arr [DEPTH];
  logic [DATA_W-1:0] m_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign a_arr[i] = P_ADDR[i*ADDR_W +: ADDR_W];
    assign d_arr[i] = P_DATA[i*DATA_W +: DATA_W];
    assign c_arr[i] = ctrl_t'(P_CTRL[i*32 +: 32]);
    assign m_arr[i] = P_MASK[i*DATA_W +: DATA_W];
  end

  assign rd_addr = a_arr[idx];
  assign rd_data = d_arr[idx];
  assign rd_ctrl = c_arr[idx];
  assign rd_mask = m_arr[idx];

endmodule

// File: rtl/lts_bus_port.sv
module lts_bus_port
  import lts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  output logic              fin,
  output logic              fin_ok,
  output logic [DATA_W-1:0] fin_rdata,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic awv_q, wv_q, brdy_q, arv_q, rrdy_q, fin_q, ok_q;

  // handshake events, named for the assertions
  logic aw_fire, w_fire, b_fire, ar_fire, r_fire;
  assign aw_fire = awv_q  && m_awready;
  assign w_fire  = wv_q   && m_wready;
  assign b_fire  = brdy_q && m_bvalid;
  assign ar_fire = arv_q  && m_arready;
  assign r_fire  = rrdy_q && m_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      awv_q   <= 1'b0;
      wv_q    <= 1'b0;
      brdy_q  <= 1'b0;
      arv_q   <= 1'b0;
      rrdy_q  <= 1'b0;
      fin_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        addr_q  <= op_addr;
        wdata_q <= op_data;
        if (op_write) begin
          awv_q  <= 1'b1;
          wv_q   <= 1'b1;
          brdy_q <= 1'b1;
        end else begin
          arv_q  <= 1'b1;
          rrdy_q <= 1'b1;
        end
      end
      if (aw_fire) awv_q <= 1'b0;
      if (w_fire)  wv_q  <= 1'b0;
      if (ar_fire) arv_q <= 1'b0;
      if (b_fire) begin
        brdy_q  <= 1'b0;
        fin_q   <= 1'b1;
        ok_q    <= (m_bresp == RESP_OKAY);
        rdata_q <= '0;
      end
      if (r_fire) begin
        rrdy_q  <= 1'b0;
        fin_q   <= 1'b1;
        ok_q    <= (m_rresp == RESP_OKAY);
        rdata_q <= m_rdata;
      end
    end
  end

  assign m_awaddr  = addr_q;
  assign m_araddr  = addr_q;
  assign m_wdata   = wdata_q;
  assign m_wstrb   = '1;
  assign m_awvalid = awv_q;
  assign m_wvalid  = wv_q;
  assign m_bready  = brdy_q;
  assign m_arvalid = arv_q;
  assign m_rready  = rrdy_q;
  assign fin       = fin_q;
  assign fin_ok    = ok_q;
  assign fin_rdata = rdata_q;

  p_aw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  p_w_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata));
  p_ar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
  p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_awvalid && m_arvalid));
  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !(m_bready || m_rready));

endmodule

// File: rtl/lts_scorer.sv
module lts_scorer #(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              judge,
  input  logic              is_write,
  input  logic              count_en,
  input  logic              resp_ok,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] expect_data,
  input  logic [DATA_W-1:0] mask,
  output logic              pass,
  output logic [ERR_W-1:0]  err_count
);

  function automatic logic f_match(logic [DATA_W-1:0] got,
                                   logic [DATA_W-1:0] want,
                                   logic [DATA_W-1:0] sel);
    return ((got ^ want) & sel) == '0;
  endfunction

  function automatic logic [ERR_W-1:0] f_sat_inc(logic [ERR_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic [ERR_W-1:0] err_q;
  logic fail_evt, err_bump;

  assign pass     = resp_ok && (is_write || f_match(rdata, expect_data, mask));
  assign fail_evt = judge && !pass;
  assign err_bump = fail_evt && count_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else if (err_bump) err_q <= f_sat_inc(err_q);
  end

  assign err_count = err_q;

  p_err_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_count) |=> (&err_count));
  p_err_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !judge |=> $stable(err_count));

endmodule

// File: rtl/lite_test_sequencer.sv
module lite_test_sequencer
  import lts_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 16,
  parameter logic [DEPTH*ADDR_W-1:0] P_ADDR = '1,
  parameter logic [DEPTH*DATA_W-1:0] P_DATA = '0,
  parameter logic [DEPTH*32-1:0]     P_CTRL = '0,
  parameter logic [DEPTH*DATA_W-1:0] P_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic                done,
  output logic                status,
  output logic [ERR_W-1:0]    err_count
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [IDX_W-1:0] f_wrap(logic [7:0] t);
    return IDX_W'({1'b0, t} % 9'(DEPTH));
  endfunction

  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ent_wr_q, ent_cnt_q;
  logic [7:0]        ent_pass_q, ent_fail_q;
  logic [DATA_W-1:0] ent_exp_q, ent_mask_q;
  logic              status_q;

  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data, rom_mask;
  ctrl_t             rom_ctrl;

  logic              fin, fin_ok, pass;
  logic [DATA_W-1:0] fin_rdata;

  // internal events, named for the assertions
  logic at_pick, is_nop, is_bad, launch, judge;
  logic [IDX_W-1:0] next_idx;

  lts_rom #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .P_ADDR(P_ADDR), .P_DATA(P_DATA), .P_CTRL(P_CTRL), .P_MASK(P_MASK)
  ) u_rom (
    .idx(idx_q), .rd_addr(rom_addr), .rd_data(rom_data),
    .rd_ctrl(rom_ctrl), .rd_mask(rom_mask)
  );

  assign at_pick  = (state_q == ST_PICK);
  assign is_nop   = (rom_addr == '1);
  assign is_bad   = !ctrl_legal(rom_ctrl);
  assign launch   = at_pick && !is_nop && !is_bad;
  assign judge    = (state_q == ST_BUSY) && fin;
  assign next_idx = pass ? f_wrap(ent_pass_q) : f_wrap(ent_fail_q);

  lts_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .start(launch), .op_write(rom_ctrl.is_write),
    .op_addr(rom_addr), .op_data(rom_data),
    .fin(fin), .fin_ok(fin_ok), .fin_rdata(fin_rdata),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  lts_scorer #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_score (
    .clk(clk), .rst_n(rst_n), .judge(judge),
    .is_write(ent_wr_q), .count_en(ent_cnt_q), .resp_ok(fin_ok),
    .rdata(fin_rdata), .expect_data(ent_exp_q), .mask(ent_mask_q),
    .pass(pass), .err_count(err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_PICK;
      idx_q      <= '0;
      ent_wr_q   <= 1'b0;
      ent_cnt_q  <= 1'b0;
      ent_pass_q <= '0;
      ent_fail_q <= '0;
      ent_exp_q  <= '0;
      ent_mask_q <= '0;
      status_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_PICK: begin
          if (is_nop) begin
            state_q  <= ST_FINAL;
            status_q <= (err_count == '0);
          end else if (is_bad) begin
            state_q  <= ST_FINAL;
            status_q <= 1'b0;
          end else begin
            ent_wr_q   <= rom_ctrl.is_write;
            ent_cnt_q  <= rom_ctrl.count_en;
            ent_pass_q <= rom_ctrl.go_pass;
            ent_fail_q <= rom_ctrl.go_fail;
            ent_exp_q  <= rom_data;
            ent_mask_q <= rom_mask;
            state_q    <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (judge) begin
            idx_q   <= next_idx;
            state_q <= ST_PICK;
          end
        end
        default: ;
      endcase
    end
  end

  assign done   = (state_q == ST_FINAL);
  assign status = status_q;

  p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(err_count) && $stable(status));
  p_nop_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_pick && is_nop |=> !m_awvalid && !m_arvalid && done);
  p_halt_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_pick && !is_nop && is_bad |=> done && !status && !m_awvalid && !m_arvalid);
  p_bus_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_awvalid && !m_wvalid && !m_arvalid);
  p_status_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && status |-> err_count == '0);

endmodule

// File: tb/lite_test_sequencer_bench.sv
module lts_bench_slave #(
  parameter int SEED = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] awaddr,
  input  logic        awvalid,
  output logic        awready,
  input  logic [31:0] wdata,
  input  logic        wvalid,
  output logic        wready,
  output logic [1:0]  bresp,
  output logic        bvalid,
  input  logic        bready,
  input  logic [31:0] araddr,
  input  logic        arvalid,
  output logic        arready,
  output logic [31:0] rdata,
  output logic [1:0]  rresp,
  output logic        rvalid,
  input  logic        rready
);
  logic [7:0]  lfsr;
  logic        aw_got, w_got;
  logic [31:0] aw_a, w_d;
  logic [31:0] mem [16];

  assign awready = !aw_got && !bvalid && lfsr[0];
  assign wready  = !w_got && !bvalid && lfsr[1];
  assign arready = !rvalid && lfsr[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= 8'(SEED) | 8'h01;
      aw_got <= 1'b0; w_got <= 1'b0; aw_a <= '0; w_d <= '0;
      bvalid <= 1'b0; bresp <= 2'b00; rvalid <= 1'b0; rresp <= 2'b00; rdata <= '0;
      for (int k = 0; k < 16; k++) mem[k] <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (awvalid && awready) begin aw_got <= 1'b1; aw_a <= awaddr; end
      if (wvalid && wready) begin w_got <= 1'b1; w_d <= wdata; end
      if (aw_got && w_got && !bvalid && lfsr[3]) begin
        bvalid <= 1'b1;
        bresp  <= aw_a[8] ? 2'b10 : 2'b00;
        if (!aw_a[8]) mem[aw_a[5:2]] <= w_d;
        aw_got <= 1'b0; w_got <= 1'b0;
      end
      if (bvalid && bready) bvalid <= 1'b0;
      if (arvalid && arready) begin
        rvalid <= 1'b1;
        rdata  <= mem[araddr[5:2]];
        rresp  <= araddr[8] ? 2'b10 : 2'b00;
      end
      if (rvalid && rready) rvalid <= 1'b0;
    end
  end
endmodule

module lts_bench_unit #(
  parameter string NAME  = "unit",
  parameter int    ERR_W = 16,
  parameter int    SEED  = 1,
  parameter logic [511:0] P_ADDR = '1,
  parameter logic [511:0] P_DATA = '0,
  parameter logic [511:0] P_CTRL = '0,
  parameter logic [511:0] P_MASK = '0
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o,
  output int   n_chk,
  output int   n_bad
);
  logic [31:0] awaddr, wdata, araddr, rdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic awvalid, awready, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rvalid, rready, done, status;
  logic [ERR_W-1:0] err;

  lite_test_sequencer #(
    .DEPTH(16), .ADDR_W(32), .DATA_W(32), .ERR_W(ERR_W),
    .P_ADDR(P_ADDR), .P_DATA(P_DATA), .P_CTRL(P_CTRL), .P_MASK(P_MASK)
  ) u_lite_test_sequencer (
    .clk(clk), .rst_n(rst_n),
    .m_awaddr(awaddr), .m_awvalid(awvalid), .m_awready(awready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wvalid(wvalid), .m_wready(wready),
    .m_bresp(bresp), .m_bvalid(bvalid), .m_bready(bready),
    .m_araddr(araddr), .m_arvalid(arvalid), .m_arready(arready),
    .m_rdata(rdata), .m_rresp(rresp), .m_rvalid(rvalid), .m_rready(rready),
    .done(done), .status(status), .err_count(err)
  );

  lts_bench_slave #(.SEED(SEED)) u_slave (
    .clk(clk), .rst_n(rst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
  );

  // behavioural reference: walk the program with the slave's rules
  logic [31:0] ex_a [40];
  logic        ex_w [40];
  logic [31:0] ex_d [40];
  int          ex_n, ex_err;
  logic        ex_st;

  initial begin
    logic [31:0] mem [16];
    logic [31:0] a, d, c, m;
    int idx;
    bit ok;
    for (int k = 0; k < 16; k++) mem[k] = '0;
    ex_n = 0; ex_err = 0; ex_st = 1'b0; idx = 0;
    for (int step = 0; step < 40; step++) begin
      a = P_ADDR[idx*32 +: 32]; d = P_DATA[idx*32 +: 32];
      c = P_CTRL[idx*32 +: 32]; m = P_MASK[idx*32 +: 32];
      if (a == 32'hFFFF_FFFF) begin ex_st = (ex_err == 0); break; end
      if (c[31:18] != 0) begin ex_st = 1'b0; break; end
      ex_a[ex_n] = a; ex_w[ex_n] = c[16]; ex_d[ex_n] = d; ex_n++;
      if (c[16]) begin
        ok = !a[8];
        if (ok) mem[a[5:2]] = d;
      end else begin
        ok = !a[8] && (((mem[a[5:2]] ^ d) & m) == 0);
      end
      if (!ok && c[17] && ex_err < (1 << ERR_W) - 1) ex_err++;
      idx = (ok ? int'(c[15:8]) : int'(c[7:0])) % 16;
    end
  end

  int  chk_q = 0, bad_q = 0, t = 0, prev_err = 0;
  bit  rst_seen = 0, fin_seen = 0;
  assign n_chk  = chk_q;
  assign n_bad  = bad_q;
  assign done_o = done;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    chk_q++;
    if (!ok) begin
      bad_q++;
      $display("FAIL %s %s: actual=%0h expected=%0h", NAME, req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      if (!rst_seen) begin
        rst_seen = 1;
        chk(!done && !status, "R1 done/status in reset", {30'd0, done, status}, 0);
        chk(!awvalid && !wvalid && !arvalid, "R1 valids in reset", {29'd0, awvalid, wvalid, arvalid}, 0);
        chk(err == 0, "R1 counter in reset", 32'(err), 0);
      end
    end else begin
      if (bvalid && bready) begin
        chk(t < ex_n, "R5 extra write", t, ex_n);
        if (t < 40) begin
          chk(ex_w[t] == 1'b1, "R3 kind is write", 1, {31'd0, ex_w[t]});
          chk(awaddr == ex_a[t], "R5 write address order", awaddr, ex_a[t]);
          chk(wdata == ex_d[t], "R3 write data", wdata, ex_d[t]);
          chk(wstrb == 4'hF, "R11 strobes", 32'(wstrb), 32'hF);
        end
        t++;
      end
      if (rvalid && rready) begin
        chk(t < ex_n, "R5 extra read", t, ex_n);
        if (t < 40) begin
          chk(ex_w[t] == 1'b0, "R4 kind is read", 0, {31'd0, ex_w[t]});
          chk(araddr == ex_a[t], "R5 read address order", araddr, ex_a[t]);
        end
        t++;
      end
      chk(!(awvalid && arvalid), "R10 single outstanding", {31'd0, awvalid && arvalid}, 0);
      chk(int'(err) >= prev_err && int'(err) <= ex_err, "R6 counter monotone", 32'(err), ex_err);
      prev_err = int'(err);
      if (fin_seen) begin
        chk(done, "R2 done holds", {31'd0, done}, 1);
      end else if (done) begin
        fin_seen = 1;
        chk(t == ex_n, "R2 R9 transaction count", t, ex_n);
        chk(int'(err) == ex_err, "R7 final error count", 32'(err), ex_err);
        chk(status == ex_st, "R8 R9 final status", {31'd0, status}, {31'd0, ex_st});
      end
    end
  end
endmodule

module lite_test_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  localparam logic [31:0] NOP = 32'hFFFF_FFFF;

  // main program: branches on write error, masked read, bad response, wrap of index
  localparam logic [511:0] A_ADDR = {{6{NOP}}, 32'h8, 32'h8, 32'h8, 32'h10C,
    32'h4, 32'h4, 32'h108, 32'h104, 32'h4, 32'h4};
  localparam logic [511:0] A_DATA = {{6{32'h0}}, 32'h0000_1235, 32'h0000_1234,
    32'h0000_1234, 32'h0, 32'hA5A4_0001, 32'hA5A5_FFFF, 32'h2, 32'h1,
    32'hA5A5_0001, 32'hA5A5_0001};
  localparam logic [511:0] A_CTRL = {{6{32'h0}}, 32'h0000_0F0A, 32'h0000_090F,
    32'h0003_180F, 32'h0002_0F07, 32'h0002_0F06, 32'h0002_050F, 32'h0001_0F04,
    32'h0003_0F03, 32'h0002_020F, 32'h0003_010F};
  localparam logic [511:0] A_MASK = {{6{32'h0}}, 32'h0000_FFFF, 32'h0000_FFFF,
    32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0};

  // clean program: status 1
  localparam logic [511:0] B_ADDR = {{14{NOP}}, 32'h0, 32'h0};
  localparam logic [511:0] B_DATA = {{14{32'h0}}, 32'h7, 32'h7};
  localparam logic [511:0] B_CTRL = {{14{32'h0}}, 32'h0002_020F, 32'h0003_010F};
  localparam logic [511:0] B_MASK = {{14{32'h0}}, 32'hFFFF_FFFF, 32'h0};

  // saturation chain on a two-bit counter
  localparam logic [511:0] C_ADDR = {{11{NOP}}, {5{32'h100}}};
  localparam logic [511:0] C_CTRL = {{11{32'h0}}, 32'h0003_0F05, 32'h0003_0F04,
    32'h0003_0F03, 32'h0003_0F02, 32'h0003_0F01};

  // reserved control bit after one good write
  localparam logic [511:0] D_ADDR = {{14{NOP}}, 32'h4, 32'h0};
  localparam logic [511:0] D_DATA = {{14{32'h0}}, 32'h0, 32'h9};
  localparam logic [511:0] D_CTRL = {{14{32'h0}}, 32'h0013_020F, 32'h0003_010F};

  logic d_a, d_b, d_c, d_d;
  int c_a, c_b, c_c, c_d, f_a, f_b, f_c, f_d;

  lts_bench_unit #(.NAME("main"), .ERR_W(16), .SEED(3),
    .P_ADDR(A_ADDR), .P_DATA(A_DATA), .P_CTRL(A_CTRL), .P_MASK(A_MASK))
    u_main (.clk(clk), .rst_n(rst_n), .done_o(d_a), .n_chk(c_a), .n_bad(f_a));
  lts_bench_unit #(.NAME("clean"), .ERR_W(16), .SEED(77),
    .P_ADDR(B_ADDR), .P_DATA(B_DATA), .P_CTRL(B_CTRL), .P_MASK(B_MASK))
    u_clean (.clk(clk), .rst_n(rst_n), .done_o(d_b), .n_chk(c_b), .n_bad(f_b));
  lts_bench_unit #(.NAME("saturate"), .ERR_W(2), .SEED(141),
    .P_ADDR(C_ADDR), .P_DATA('0), .P_CTRL(C_CTRL), .P_MASK('0))
    u_sat (.clk(clk), .rst_n(rst_n), .done_o(d_c), .n_chk(c_c), .n_bad(f_c));
  lts_bench_unit #(.NAME("halt"), .ERR_W(16), .SEED(200),
    .P_ADDR(D_ADDR), .P_DATA(D_DATA), .P_CTRL(D_CTRL), .P_MASK('0))
    u_halt (.clk(clk), .rst_n(rst_n), .done_o(d_d), .n_chk(c_d), .n_bad(f_d));

  initial begin
    int wd_bad;
    wd_bad = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 20000 && !(d_a && d_b && d_c && d_d); cyc++) @(posedge clk);
    if (!(d_a && d_b && d_c && d_d)) begin
      wd_bad = 1;
      $display("FAIL watchdog R2: actual=%0b expected=1111", {d_a, d_b, d_c, d_d});
    end
    repeat (10) @(posedge clk);
    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks",
             f_a + f_b + f_c + f_d + wd_bad, c_a + c_b + c_c + c_d + 1);
    $finish;
  end
endmodule